// File: doc/BRIEF.md
# Clock Output Gating Controller

This block is the control core of a two-output differential clock buffer. It takes two three-level strap inputs, already resolved into 2-bit codes, and captures them exactly once: on the first cycle that the synchronized power-good input is seen high after reset. From those samples it decodes the serial-bus slave address and the PLL operating mode (low bandwidth, bypass or high bandwidth). Later low phases of power-good put the device into power-down. Later high phases bring it back out without capturing the straps again.

For each output pair the block decides whether the clock runs or is held stopped. An output runs only when all of these hold: the device is powered, its active-low enable pin is low, its register enable bit is set, and the PLL reports lock. In bypass mode the lock condition is not required. A stopped pair is parked at true/complement levels taken from a 2-bit register field. The run/stop decision is registered, and it changes only while the output clock sits at its stopped level, so no shortened pulse reaches the drivers.

All asynchronous inputs pass through a two-flop synchronizer. The register bits reach the block through a plain parallel write/read interface.

Top module: `clkgate_ctrl`

## Requirements
- R1: The straps are captured only on the first synchronized high of `pwr_good_i` after reset. After a later power-down and power-up, `addr_byte_o` and `mode_readback_o` keep their first values even if the strap inputs have changed.
- R2: The address strap codes decode as follows: 00 gives 7-bit address 0x6B, 01 or 10 gives 0x6C, and 11 gives 0x6D. `addr_byte_o` is that address shifted left by one, with a 0 (write) in bit 0.
- R3: The mode strap codes decode as follows: 00 gives low bandwidth (code 00), 01 or 10 gives bypass (code 01), and 11 gives high bandwidth (code 11). At capture the code appears on `mode_readback_o` and is also loaded into `mode_ctrl_o`.
- R4: After capture, a write on the mode port replaces `mode_ctrl_o` and so changes the operating mode. `mode_readback_o` stays at the strap value.
- R5: Output i runs (`run_o[i]`=1) only when all of these are true: straps are captured, `pwr_good_i` is high, `oe_n_i[i]`=0, `reg_oe_o[i]`=1, and the lock condition of R6 is met. Otherwise output i is stopped.
- R6: In low-bandwidth and high-bandwidth modes the outputs stay stopped while `pll_lock_i` is low. In bypass mode (control code 01) the outputs run whatever the value of `pll_lock_i`.
- R7: `pll_en_o` is 1 only when the device is powered (straps captured and power-good high) and the control mode is not bypass.
- R8: A low on `pwr_good_i` after capture stops every output and clears `pll_en_o`. A later high resumes operation.
- R9: For each output pair, `park_true_o[i]` shows bit 1 of the stop-level field and `park_comp_o[i]` shows bit 0 while the pair is stopped. Both are 0 while the pair runs. The field resets to 00.
- R10: `run_o` changes only on clock edges where `out_phase_i` is 0. While `out_phase_i` is 1, `run_o` holds its value.
- R11: After reset, the block shows the following: `run_o`=0, `pll_en_o`=0, `straps_done_o`=0, `reg_oe_o` all ones, `stop_lvl_o`=00 and `mode_ctrl_o`=00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good_i | input | 1 | Power-good / power-down request, asynchronous |
| addr_strap_i | input | 2 | Address strap code (00 low, 01/10 mid, 11 high) |
| mode_strap_i | input | 2 | Mode strap code (00 low, 01/10 mid, 11 high) |
| pll_lock_i | input | 1 | PLL lock indication, asynchronous |
| oe_n_i | input | NOUT | Active-low per-output enable pins, asynchronous |
| out_phase_i | input | 1 | Output clock level in the control domain; 0 is the stopped level |
| reg_oe_we_i | input | 1 | Write strobe for the register enable bits |
| reg_oe_wdata_i | input | NOUT | Register enable write data |
| reg_mode_we_i | input | 1 | Write strobe for the mode control field |
| reg_mode_wdata_i | input | 2 | Mode control write data |
| reg_stop_we_i | input | 1 | Write strobe for the stop-level field |
| reg_stop_wdata_i | input | 2 | Stop-level write data (bit 1 true, bit 0 complement) |
| straps_done_o | output | 1 | Straps have been captured |
| addr_byte_o | output | 8 | Slave address byte with write bit |
| mode_readback_o | output | 2 | Captured strap mode code |
| mode_ctrl_o | output | 2 | Mode code in effect |
| reg_oe_o | output | NOUT | Register enable bits |
| stop_lvl_o | output | 2 | Stop-level field |
| pll_en_o | output | 1 | PLL enable |
| run_o | output | NOUT | Per-output run state |
| park_true_o | output | NOUT | True-side parked level |
| park_comp_o | output | NOUT | Complement-side parked level |

## Verification
A wrong capture flag or a wrong strap sample shows up in `addr_byte_o` and `mode_readback_o` within three clocks of the first power-good high. It is still visible after any number of power cycles, which is how a re-capture fault is exposed. A wrong gating term appears on `run_o` one clock after the synchronized input changes, so at most four clocks after the pin moves, provided `out_phase_i` is low. An update that ignores the phase would show as a change in `run_o` during a window where `out_phase_i` is held high. A wrong stop-level mapping is visible on the park outputs in the same clock as the run state.

// File: rtl/clkgate_pkg.sv
// Shared constants and decode functions for the clock output gating controller.
// Assumes strap codes arrive pre-resolved as 2-bit values.
package clkgate_pkg;

    localparam logic [1:0] MODE_LOBW = 2'b00;
    localparam logic [1:0] MODE_BYP  = 2'b01;
    localparam logic [1:0] MODE_HIBW = 2'b11;

    localparam logic [6:0] ADDR_LO  = 7'h6B;
    localparam logic [6:0] ADDR_MID = 7'h6C;
    localparam logic [6:0] ADDR_HI  = 7'h6D;

    // Map a strap code to the slave address; 01 and 10 both mean mid.
    function automatic logic [6:0] strap_to_addr(input logic [1:0] code);
        case (code)
            2'b00:   return ADDR_LO;
            2'b11:   return ADDR_HI;
            default: return ADDR_MID;
        endcase
    endfunction

    // Map a strap code to the PLL mode code; 01 and 10 both mean bypass.
    function automatic logic [1:0] strap_to_mode(input logic [1:0] code);
        case (code)
            2'b00:   return MODE_LOBW;
            2'b11:   return MODE_HIBW;
            default: return MODE_BYP;
        endcase
    endfunction

    // True when a control code selects bypass.
    function automatic logic is_bypass(input logic [1:0] code);
        return (code == 2'b01) || (code == 2'b10);
    endfunction

endpackage

// File: rtl/clkgate_sync.sv
// Multi-stage synchronizer bank for asynchronous control inputs.
// Assumes each bit is independent (no multi-bit coherence needed) and STAGES >= 2.
module clkgate_sync #(
    parameter int         W       = 4,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    // Shift the input through the flop chain; reset to the safe value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
        end else begin
            stg[0] <= d_i;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/clkgate_strap.sv
// Captures the strap codes once, on the first synchronized power-good high,
// and decodes address and mode. Assumes inputs are already synchronized.
module clkgate_strap
    import clkgate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_s_i,
    input  logic [1:0] addr_code_i,
    input  logic [1:0] mode_code_i,
    output logic       done_o,
    output logic       latch_o,
    output logic [6:0] addr_o,
    output logic [1:0] mode_o
);
    assign latch_o = pwr_s_i && !done_o;

    // Capture and decode straps on the first power-good high only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            addr_o <= ADDR_LO;
            mode_o <= MODE_LOBW;
        end else if (latch_o) begin
            done_o <= 1'b1;
            addr_o <= strap_to_addr(addr_code_i);
            mode_o <= strap_to_mode(mode_code_i);
        end
    end

    p_hold_straps_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (done_o && $stable(addr_o) && $stable(mode_o)));

    p_addr_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (addr_o == ADDR_LO || addr_o == ADDR_MID || addr_o == ADDR_HI));

endmodule

// File: rtl/clkgate_regs.sv
// Parallel-access configuration registers: per-output enables, mode control
// and stop-level field. Strap capture loads the mode and takes priority over a write.
module clkgate_regs #(
    parameter int NOUT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            latch_i,
    input  logic [1:0]      latch_mode_i,
    input  logic            oe_we_i,
    input  logic [NOUT-1:0] oe_wdata_i,
    input  logic            mode_we_i,
    input  logic [1:0]      mode_wdata_i,
    input  logic            stop_we_i,
    input  logic [1:0]      stop_wdata_i,
    output logic [NOUT-1:0] oe_o,
    output logic [1:0]      mode_o,
    output logic [1:0]      stop_o
);
    // Enable bits: reset to all ones, written from the parallel port.
    always_ff @(posedge clk) begin
        if (!rst_n)       oe_o <= '1;
        else if (oe_we_i) oe_o <= oe_wdata_i;
    end

    // Mode control: loaded from straps at capture, otherwise writable.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_o <= 2'b00;
        else if (latch_i)   mode_o <= latch_mode_i;
        else if (mode_we_i) mode_o <= mode_wdata_i;
    end

    // Stop-level field: reset to low/low.
    always_ff @(posedge clk) begin
        if (!rst_n)         stop_o <= 2'b00;
        else if (stop_we_i) stop_o <= stop_wdata_i;
    end

    p_mode_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we_i && !latch_i) |=> (mode_o == $past(mode_wdata_i)));

endmodule

// File: rtl/clkgate_outgate.sv
// Per-output run/stop decision and parked levels. The registered run state
// only updates while the output clock is at its stopped level (phase 0).
module clkgate_outgate
    import clkgate_pkg::*;
#(
    parameter int NOUT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            powered_i,
    input  logic            bypass_i,
    input  logic            lock_i,
    input  logic            phase_i,
    input  logic [NOUT-1:0] oe_n_i,
    input  logic [NOUT-1:0] reg_oe_i,
    input  logic [1:0]      stop_lvl_i,
    output logic [NOUT-1:0] run_o,
    output logic [NOUT-1:0] park_true_o,
    output logic [NOUT-1:0] park_comp_o
);
    logic clk_ok;
    assign clk_ok = powered_i && (bypass_i || lock_i);

    for (genvar i = 0; i < NOUT; i++) begin : g_out
        logic want;
        assign want = clk_ok && reg_oe_i[i] && !oe_n_i[i];

        // Take the new run decision only at the stopped clock level.
        always_ff @(posedge clk) begin
            if (!rst_n)        run_o[i] <= 1'b0;
            else if (!phase_i) run_o[i] <= want;
        end

        assign park_true_o[i] = !run_o[i] && stop_lvl_i[1];
        assign park_comp_o[i] = !run_o[i] && stop_lvl_i[0];

        p_start_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run_o[i]) |-> $past(powered_i && reg_oe_i[i] && !oe_n_i[i]));

        p_start_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run_o[i]) |-> $past(lock_i || bypass_i));
    end

    p_phase_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        phase_i |=> $stable(run_o));

    p_pdn_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!powered_i && !phase_i) |=> (run_o == '0));

endmodule

// File: rtl/clkgate_ctrl.sv
// Top of the clock output gating controller: synchronizes async controls,
// captures straps, holds configuration and drives per-output gating.
// Assumes out_phase_i is already in the control clock domain.
module clkgate_ctrl
    import clkgate_pkg::*;
#(
    parameter int NOUT   = 2,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_good_i,
    input  logic [1:0]      addr_strap_i,
    input  logic [1:0]      mode_strap_i,
    input  logic            pll_lock_i,
    input  logic [NOUT-1:0] oe_n_i,
    input  logic            out_phase_i,
    input  logic            reg_oe_we_i,
    input  logic [NOUT-1:0] reg_oe_wdata_i,
    input  logic            reg_mode_we_i,
    input  logic [1:0]      reg_mode_wdata_i,
    input  logic            reg_stop_we_i,
    input  logic [1:0]      reg_stop_wdata_i,
    output logic            straps_done_o,
    output logic [7:0]      addr_byte_o,
    output logic [1:0]      mode_readback_o,
    output logic [1:0]      mode_ctrl_o,
    output logic [NOUT-1:0] reg_oe_o,
    output logic [1:0]      stop_lvl_o,
    output logic            pll_en_o,
    output logic [NOUT-1:0] run_o,
    output logic [NOUT-1:0] park_true_o,
    output logic [NOUT-1:0] park_comp_o
);
    localparam int SW = 2 + NOUT + 4;
    localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b0, {NOUT{1'b1}}, 4'b0000};

    logic [SW-1:0] raw_in, syn_in;
    logic          pwr_s, lock_s;
    logic [NOUT-1:0] oe_n_s;
    logic [1:0]    addr_s, mode_s;
    logic          latch, powered, bypass;
    logic [6:0]    addr7;

    assign raw_in = {pwr_good_i, pll_lock_i, oe_n_i, mode_strap_i, addr_strap_i};
    assign {pwr_s, lock_s, oe_n_s, mode_s, addr_s} = syn_in;

    clkgate_sync #(.W(SW), .STAGES(STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn_in)
    );

    clkgate_strap u_strap (
        .clk(clk), .rst_n(rst_n), .pwr_s_i(pwr_s),
        .addr_code_i(addr_s), .mode_code_i(mode_s),
        .done_o(straps_done_o), .latch_o(latch),
        .addr_o(addr7), .mode_o(mode_readback_o)
    );

    clkgate_regs #(.NOUT(NOUT)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .latch_i(latch), .latch_mode_i(strap_to_mode(mode_s)),
        .oe_we_i(reg_oe_we_i), .oe_wdata_i(reg_oe_wdata_i),
        .mode_we_i(reg_mode_we_i), .mode_wdata_i(reg_mode_wdata_i),
        .stop_we_i(reg_stop_we_i), .stop_wdata_i(reg_stop_wdata_i),
        .oe_o(reg_oe_o), .mode_o(mode_ctrl_o), .stop_o(stop_lvl_o)
    );

    assign powered     = straps_done_o && pwr_s;
    assign bypass      = is_bypass(mode_ctrl_o);
    assign pll_en_o    = powered && !bypass;
    assign addr_byte_o = {addr7, 1'b0};

    clkgate_outgate #(.NOUT(NOUT)) u_gate (
        .clk(clk), .rst_n(rst_n),
        .powered_i(powered), .bypass_i(bypass), .lock_i(lock_s),
        .phase_i(out_phase_i), .oe_n_i(oe_n_s), .reg_oe_i(reg_oe_o),
        .stop_lvl_i(stop_lvl_o),
        .run_o(run_o), .park_true_o(park_true_o), .park_comp_o(park_comp_o)
    );

    p_pll_off_unpowered_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !straps_done_o |-> !pll_en_o);

endmodule

// File: tb/clkgate_ctrl_tb.sv
// Self-checking bench: a gating vector table, then directed tests.
module clkgate_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NOUT = 2;
    localparam int SETTLE = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good_i = 1'b0;
    logic [1:0] addr_strap_i = 2'b11, mode_strap_i = 2'b11;
    logic pll_lock_i = 1'b0;
    logic [NOUT-1:0] oe_n_i = '0;
    logic out_phase_i = 1'b0;
    logic reg_oe_we_i = 1'b0, reg_mode_we_i = 1'b0, reg_stop_we_i = 1'b0;
    logic [NOUT-1:0] reg_oe_wdata_i = '0;
    logic [1:0] reg_mode_wdata_i = '0, reg_stop_wdata_i = '0;
    logic straps_done_o, pll_en_o;
    logic [7:0] addr_byte_o;
    logic [1:0] mode_readback_o, mode_ctrl_o, stop_lvl_o;
    logic [NOUT-1:0] reg_oe_o, run_o, park_true_o, park_comp_o;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkgate_ctrl #(.NOUT(NOUT)) u_dut (.*);

    // Vector: {oe_n[1:0], reg_oe[1:0], lock, expected run[1:0]} in high-BW mode (R5, R6).
    localparam logic [6:0] VECS [8] = '{
        {2'b00, 2'b11, 1'b1, 2'b11},
        {2'b00, 2'b11, 1'b0, 2'b00},
        {2'b01, 2'b11, 1'b1, 2'b10},
        {2'b10, 2'b11, 1'b1, 2'b01},
        {2'b00, 2'b01, 1'b1, 2'b01},
        {2'b00, 2'b10, 1'b1, 2'b10},
        {2'b11, 2'b11, 1'b1, 2'b00},
        {2'b00, 2'b00, 1'b1, 2'b00}
    };

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_oe(logic [NOUT-1:0] v);
        reg_oe_we_i = 1'b1; reg_oe_wdata_i = v; step(1); reg_oe_we_i = 1'b0;
    endtask

    task automatic wr_mode(logic [1:0] v);
        reg_mode_we_i = 1'b1; reg_mode_wdata_i = v; step(1); reg_mode_we_i = 1'b0;
    endtask

    task automatic wr_stop(logic [1:0] v);
        reg_stop_we_i = 1'b1; reg_stop_wdata_i = v; step(1); reg_stop_we_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pwr_good_i = 1'b0; step(4); rst_n = 1'b1; step(1);
    endtask

    initial begin
        step(1);
        do_reset();
        // R11: reset values
        chk("R11 run", run_o, 0);
        chk("R11 pll_en", pll_en_o, 0);
        chk("R11 done", straps_done_o, 0);
        chk("R11 reg_oe", reg_oe_o, 2'b11);
        chk("R11 stop", stop_lvl_o, 0);
        chk("R11 mode_ctrl", mode_ctrl_o, 0);
        // R5: no run before power-good even with lock and pins enabled
        pll_lock_i = 1'b1; step(SETTLE);
        chk("R5 unpowered", run_o, 0);
        chk("R7 unpowered", pll_en_o, 0);
        // R2, R3: capture high/high straps
        pwr_good_i = 1'b1; step(SETTLE);
        chk("R2 addr hi", addr_byte_o, 8'hDA);
        chk("R3 readback hi", mode_readback_o, 2'b11);
        chk("R3 ctrl hi", mode_ctrl_o, 2'b11);
        chk("R7 pll_en on", pll_en_o, 1);
        // R5/R6 vector walk
        foreach (VECS[v]) begin
            oe_n_i = VECS[v][6:5]; pll_lock_i = VECS[v][2];
            wr_oe(VECS[v][4:3]);
            step(SETTLE);
            chk($sformatf("R5 R6 vec%0d", v), run_o, VECS[v][1:0]);
        end
        wr_oe(2'b11); oe_n_i = 2'b00; pll_lock_i = 1'b1; step(SETTLE);
        chk("R5 restore", run_o, 2'b11);
        // R9: running outputs park at 0 even with nonzero field
        wr_stop(2'b11); step(1);
        chk("R9 running true", park_true_o, 0);
        chk("R9 running comp", park_comp_o, 0);
        // R10: phase high freezes run state
        out_phase_i = 1'b1; oe_n_i = 2'b11; step(SETTLE);
        chk("R10 frozen", run_o, 2'b11);
        out_phase_i = 1'b0; step(2);
        chk("R10 released", run_o, 2'b00);
        // R9: stopped outputs show field bits
        wr_stop(2'b10); step(1);
        chk("R9 true", park_true_o, 2'b11);
        chk("R9 comp", park_comp_o, 2'b00);
        wr_stop(2'b01); step(1);
        chk("R9 true b", park_true_o, 2'b00);
        chk("R9 comp b", park_comp_o, 2'b11);
        oe_n_i = 2'b00; step(SETTLE);
        // R8: power-down stops all and turns PLL off
        pwr_good_i = 1'b0; step(SETTLE);
        chk("R8 stopped", run_o, 0);
        chk("R8 pll off", pll_en_o, 0);
        // R1: new straps not captured on later power-up
        addr_strap_i = 2'b00; mode_strap_i = 2'b01;
        pwr_good_i = 1'b1; step(SETTLE);
        chk("R1 addr kept", addr_byte_o, 8'hDA);
        chk("R1 mode kept", mode_readback_o, 2'b11);
        chk("R8 resumed", run_o, 2'b11);
        // R4, R6: write bypass, drop lock
        wr_mode(2'b01); pll_lock_i = 1'b0; step(SETTLE);
        chk("R4 ctrl", mode_ctrl_o, 2'b01);
        chk("R4 readback", mode_readback_o, 2'b11);
        chk("R6 bypass runs", run_o, 2'b11);
        chk("R7 bypass pll off", pll_en_o, 0);
        // R4: back to low-BW, lock gates again
        wr_mode(2'b00); step(SETTLE);
        chk("R6 lock gates", run_o, 2'b00);
        chk("R7 pll on", pll_en_o, 1);
        // R2, R3: mid via code 10 and code 01
        addr_strap_i = 2'b01; mode_strap_i = 2'b10; step(3);
        do_reset(); pwr_good_i = 1'b1; step(SETTLE);
        chk("R2 addr mid", addr_byte_o, 8'hD8);
        chk("R3 mid 10", mode_readback_o, 2'b01);
        chk("R6 strap bypass", run_o, 2'b11);
        addr_strap_i = 2'b10; mode_strap_i = 2'b00; step(3);
        do_reset(); pwr_good_i = 1'b1; step(SETTLE);
        chk("R2 addr mid 10", addr_byte_o, 8'hD8);
        chk("R3 low", mode_readback_o, 2'b00);
        addr_strap_i = 2'b00; step(3);
        do_reset(); pwr_good_i = 1'b1; step(SETTLE);
        chk("R2 addr lo", addr_byte_o, 8'hD6);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule